// File: doc/BRIEF.md
# Storage Card Clock Divider

This block produces the interface clock for a storage card from one of two free-running source clocks: a fast general-purpose PLL clock or the 24 MHz crystal oscillator. The selected source drives a programmable integer divider. A fixed divide-by-two stage follows it, so the card clock spends exactly (div + 1) source cycles high and (div + 1) source cycles low. The duty cycle is 50% for every divider value, odd or even.

Software, or a boot sequencer, sets the block up through a small write port clocked by the oscillator. A direct write loads the source code and the divider field together. A second write path takes the division ratio wanted against the PLL. When that ratio does not fit the divider field, this path moves to the oscillator and uses a second ratio given against the oscillator. The active source code, the divider and an error flag are always readable.

Switching from one source to the other goes through a handshake in which each clock turns itself off before the other turns on, so the card clock never sees a runt edge. A new divider value takes effect only when the output next toggles. Selecting a source code the block does not support raises the error flag and holds the card clock low.

Top module: `sdclk_gen`

## Requirements
- R1: While reset is asserted `clk_out` is low. After reset the source code reads 1 (oscillator), the divider reads 0 and `src_err` is low.
- R2: A direct write (`cfg_we`) loads `cfg_src` and `cfg_div` in the same oscillator cycle, and both appear on `rd_src` and `rd_div` at the next rising edge of `osc_clk`.
- R3: With a valid source selected and divider value d, `clk_out` stays high for d+1 cycles of the selected source and then low for d+1 cycles. This holds for every d from 0 to 63, odd or even.
- R4: Source code 0 selects `pll_clk` and source code 1 selects `osc_clk`.
- R5: Source codes 2 and 3 (an alternate PLL and a 480 MHz PHY clock) are unsupported. Writing either one sets `src_err` and holds `clk_out` low until a supported code is written, which clears `src_err`.
- R6: An assisted write (`auto_we`) with PLL ratio r, where r ≤ 64, selects source 0 with divider r−1. A ratio of 0 is treated as 1 and gives divider 0.
- R7: An assisted write whose PLL ratio is above 64 selects source 1. The divider is then the oscillator ratio minus one, saturated at 63 (oscillator ratio 0 gives 0).
- R8: When `cfg_we` and `auto_we` are high in the same cycle, the direct write wins and the assisted request is dropped.
- R9: When the divider changes, the output half-period already in progress finishes at its old length, and the new length applies from the next toggle on.
- R10: The two source clock enables are never high at the same time. After a switch of source, the output settles to the half-period set by the new source and divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pll_clk | input | 1 | General-purpose PLL source clock (code 0) |
| osc_clk | input | 1 | Oscillator source clock (code 1); also clocks the configuration port |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Direct write strobe |
| cfg_src | input | 2 | Source code for a direct write |
| cfg_div | input | DIV_W | Divider field for a direct write |
| auto_we | input | 1 | Assisted write strobe |
| auto_pll_ratio | input | RATIO_W | Wanted division ratio against the PLL |
| auto_osc_ratio | input | RATIO_W | Wanted division ratio against the oscillator, used on fallback |
| rd_src | output | 2 | Source code in effect |
| rd_div | output | DIV_W | Divider field in effect |
| src_err | output | 1 | Unsupported source code selected |
| clk_out | output | 1 | Card clock |

## Verification
The bench uses the default parameters: a 6-bit divider field, 10-bit ratio inputs and one synchronising flop ahead of each enable's falling-edge flop. With these values the full-scale divider of 63 can be measured on the PLL clock, and ratios up to 1023 can be given, which covers both the fitting boundary at 64 and saturation of the oscillator divider. Running the PLL clock at 2.5 times the oscillator rate makes a source switch visible in the measured run lengths.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

   // Source codes: the order matters, it is the value on the config port.
   typedef enum logic [1:0] {
      SRC_GPLL   = 2'd0,
      SRC_OSC    = 2'd1,
      SRC_ALTPLL = 2'd2,
      SRC_PHY480 = 2'd3
   } src_e;

   localparam int unsigned N_SRC = 2;

   function automatic logic src_ok(input logic [1:0] s);
      return (s == SRC_GPLL) || (s == SRC_OSC);
   endfunction

endpackage

// File: rtl/sdclk_cfg.sv
module sdclk_cfg
   import sdclk_pkg::*;
#(
   parameter int unsigned DIV_W   = 6,
   parameter int unsigned RATIO_W = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [1:0]         cfg_src,
   input  logic [DIV_W-1:0]   cfg_div,
   input  logic               auto_we,
   input  logic [RATIO_W-1:0] auto_pll_ratio,
   input  logic [RATIO_W-1:0] auto_osc_ratio,
   output logic [1:0]         src_q,
   output logic [DIV_W-1:0]   div_q,
   output logic               err_q
);

   localparam int unsigned        DIV_MAX = (1 << DIV_W) - 1;
   localparam logic [RATIO_W-1:0] RMAX    = RATIO_W'(DIV_MAX);

   generate
      if (RATIO_W <= DIV_W) begin : g_bad_ratio_w
         $error("sdclk_cfg: RATIO_W must be wider than DIV_W");
      end
   endgenerate

   function automatic logic [RATIO_W-1:0] ratio_to_div(input logic [RATIO_W-1:0] r);
      return (r == '0) ? '0 : r - RATIO_W'(1);
   endfunction

   logic [RATIO_W-1:0] pll_need, osc_need;
   logic               pll_fits;
   logic [DIV_W-1:0]   osc_div;
   logic [1:0]         nxt_src;
   logic [DIV_W-1:0]   nxt_div;

   always_comb begin
      pll_need = ratio_to_div(auto_pll_ratio);
      osc_need = ratio_to_div(auto_osc_ratio);
      pll_fits = (pll_need <= RMAX);
      osc_div  = (osc_need > RMAX) ? {DIV_W{1'b1}} : osc_need[DIV_W-1:0];
      nxt_src  = src_q;
      nxt_div  = div_q;
      // R8: the direct write has priority over the assisted one
      if (cfg_we) begin
         nxt_src = cfg_src;
         nxt_div = cfg_div;
      end else if (auto_we) begin
         if (pll_fits) begin
            nxt_src = SRC_GPLL;
            nxt_div = pll_need[DIV_W-1:0];
         end else begin
            nxt_src = SRC_OSC;
            nxt_div = osc_div;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q <= SRC_OSC;
         div_q <= '0;
         err_q <= 1'b0;
      end else begin
         src_q <= nxt_src;
         div_q <= nxt_div;
         err_q <= !src_ok(nxt_src);
      end
   end

   assert_cfg_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> (src_q == $past(cfg_src)) && (div_q == $past(cfg_div)));

   assert_auto_fit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_we && !cfg_we && auto_pll_ratio <= RATIO_W'(DIV_MAX + 1))
      |=> (src_q == SRC_GPLL) && !err_q);

   assert_fallback_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_we && !cfg_we && auto_pll_ratio > RATIO_W'(DIV_MAX + 1))
      |=> (src_q == SRC_OSC) && !err_q);

endmodule

// File: rtl/sdclk_gate_cell.sv
module sdclk_gate_cell #(
   parameter int unsigned STAGES = 1
) (
   input  logic src_clk,
   input  logic rst_n,
   input  logic want,
   input  logic other_en,
   output logic en,
   output logic gclk
);

   logic              d;
   logic [STAGES-1:0] pos_q;
   logic              neg_q;

   assign d = want & ~other_en;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge src_clk or negedge rst_n) begin
            if (!rst_n) pos_q <= 1'b0;
            else        pos_q <= d;
         end
      end else begin : g_chain
         always_ff @(posedge src_clk or negedge rst_n) begin
            if (!rst_n) pos_q <= '0;
            else        pos_q <= {pos_q[STAGES-2:0], d};
         end
      end
   endgenerate

   // enable moves only while this source clock is low
   always_ff @(negedge src_clk or negedge rst_n) begin
      if (!rst_n) neg_q <= 1'b0;
      else        neg_q <= pos_q[STAGES-1];
   end

   assign en   = neg_q;
   assign gclk = src_clk & neg_q;

endmodule

// File: rtl/sdclk_divider.sv
module sdclk_divider #(
   parameter int unsigned DIV_W = 6
) (
   input  logic             clk,
   input  logic             arst_n,
   input  logic [DIV_W-1:0] div_in,
   output logic             tog_q
);

   logic [DIV_W-1:0] cnt_q, lim_q;
   logic             wrap;

   assign wrap = (cnt_q == lim_q);

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         cnt_q <= '0;
         lim_q <= '0;
         tog_q <= 1'b0;
      end else if (wrap) begin
         cnt_q <= '0;
         lim_q <= div_in;
         tog_q <= ~tog_q;
      end else begin
         cnt_q <= cnt_q + DIV_W'(1);
      end
   end

   assert_div_boundary_R9: assert property (@(posedge clk) disable iff (!arst_n)
      (lim_q != $past(lim_q)) |-> (tog_q != $past(tog_q)));

endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen
   import sdclk_pkg::*;
#(
   parameter int unsigned DIV_W       = 6,
   parameter int unsigned RATIO_W     = 10,
   parameter int unsigned SYNC_STAGES = 1
) (
   input  logic               pll_clk,
   input  logic               osc_clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [1:0]         cfg_src,
   input  logic [DIV_W-1:0]   cfg_div,
   input  logic               auto_we,
   input  logic [RATIO_W-1:0] auto_pll_ratio,
   input  logic [RATIO_W-1:0] auto_osc_ratio,
   output logic [1:0]         rd_src,
   output logic [DIV_W-1:0]   rd_div,
   output logic               src_err,
   output logic               clk_out
);

   generate
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("sdclk_gen: SYNC_STAGES must be at least 1");
      end
      if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div_w
         $error("sdclk_gen: DIV_W out of range");
      end
   endgenerate

   logic [1:0]       src_q;
   logic [DIV_W-1:0] div_q;
   logic             err_q;

   sdclk_cfg #(.DIV_W(DIV_W), .RATIO_W(RATIO_W)) u_cfg (
      .clk            (osc_clk),
      .rst_n          (rst_n),
      .cfg_we         (cfg_we),
      .cfg_src        (cfg_src),
      .cfg_div        (cfg_div),
      .auto_we        (auto_we),
      .auto_pll_ratio (auto_pll_ratio),
      .auto_osc_ratio (auto_osc_ratio),
      .src_q          (src_q),
      .div_q          (div_q),
      .err_q          (err_q)
   );

   // index equals source code
   logic [N_SRC-1:0] src_clks, want, en, gclk;

   assign src_clks = {osc_clk, pll_clk};
   assign want[0]  = (src_q == SRC_GPLL);
   assign want[1]  = (src_q == SRC_OSC);

   generate
      for (genvar i = 0; i < N_SRC; i++) begin : g_src
         sdclk_gate_cell #(.STAGES(SYNC_STAGES)) u_cell (
            .src_clk  (src_clks[i]),
            .rst_n    (rst_n),
            .want     (want[i]),
            .other_en (en[N_SRC-1-i]),
            .en       (en[i]),
            .gclk     (gclk[i])
         );
      end
   endgenerate

   logic mux_clk, div_rst_n, tog;

   assign mux_clk   = |gclk;
   assign div_rst_n = rst_n & ~err_q;

   sdclk_divider #(.DIV_W(DIV_W)) u_div (
      .clk    (mux_clk),
      .arst_n (div_rst_n),
      .div_in (div_q),
      .tog_q  (tog)
   );

   assign clk_out = tog;
   assign rd_src  = src_q;
   assign rd_div  = div_q;
   assign src_err = err_q;

   assert_src_excl_R10: assert property (@(posedge osc_clk) disable iff (!rst_n)
      $onehot0(en));

   assert_err_low_R5: assert property (@(posedge osc_clk) disable iff (!rst_n)
      src_err |-> !clk_out);

endmodule

// File: tb/sim_sdclk_gen.sv
module sim_sdclk_gen;

   localparam int DIV_W   = 6;
   localparam int RATIO_W = 10;

   logic osc_clk = 1'b0;
   logic pll_clk = 1'b0;
   logic rst_n   = 1'b0;
   logic cfg_we  = 1'b0;
   logic [1:0] cfg_src = '0;
   logic [DIV_W-1:0] cfg_div = '0;
   logic auto_we = 1'b0;
   logic [RATIO_W-1:0] auto_pll_ratio = '0;
   logic [RATIO_W-1:0] auto_osc_ratio = '0;
   logic [1:0] rd_src;
   logic [DIV_W-1:0] rd_div;
   logic src_err, clk_out;

   always #5 osc_clk = ~osc_clk;   // 100 MHz
   always #2 pll_clk = ~pll_clk;   // 250 MHz

   sdclk_gen #(.DIV_W(DIV_W), .RATIO_W(RATIO_W)) u0 (
      .pll_clk, .osc_clk, .rst_n, .cfg_we, .cfg_src, .cfg_div,
      .auto_we, .auto_pll_ratio, .auto_osc_ratio,
      .rd_src, .rd_div, .src_err, .clk_out
   );

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;
   bit model_on = 1'b0;
   int exp_src = 1, exp_div = 0, exp_err = 0;

   // run lengths of clk_out, counted in samples of each source clock
   int q_osc[$];
   int q_pll[$];
   logic prev_o, prev_p;
   int run_o = 0, run_p = 0;
   bit seen_o = 1'b0, seen_p = 1'b0;

   always @(negedge osc_clk) begin
      if (!rst_n) begin
         run_o = 0; seen_o = 1'b0; prev_o = clk_out;
      end else if (clk_out == prev_o) begin
         run_o++;
      end else begin
         if (seen_o) q_osc.push_back(run_o);
         seen_o = 1'b1; run_o = 1; prev_o = clk_out;
      end
   end

   always @(negedge pll_clk) begin
      if (!rst_n) begin
         run_p = 0; seen_p = 1'b0; prev_p = clk_out;
      end else if (clk_out == prev_p) begin
         run_p++;
      end else begin
         if (seen_p) q_pll.push_back(run_p);
         seen_p = 1'b1; run_p = 1; prev_p = clk_out;
      end
   end

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // reference model of the readback, compared every oscillator cycle (R2, R5)
   always @(posedge osc_clk) begin
      #3;
      if (model_on) begin
         check(rd_src == exp_src[1:0], "R2", "rd_src", int'(rd_src), exp_src);
         check(rd_div == exp_div[DIV_W-1:0], "R2", "rd_div", int'(rd_div), exp_div);
         check(src_err == exp_err[0], "R5", "src_err", int'(src_err), exp_err);
      end
   end

   task automatic cfg_write(input int s, input int d);
      @(negedge osc_clk);
      cfg_we = 1'b1; cfg_src = s[1:0]; cfg_div = d[DIV_W-1:0];
      @(posedge osc_clk);
      #1;
      cfg_we = 1'b0;
      exp_src = s; exp_div = d; exp_err = (s >= 2) ? 1 : 0;
   endtask

   task automatic auto_write(input int pr, input int orr, input bit with_cfg,
                             input int s, input int d);
      int need;
      @(negedge osc_clk);
      auto_we = 1'b1;
      auto_pll_ratio = pr[RATIO_W-1:0];
      auto_osc_ratio = orr[RATIO_W-1:0];
      if (with_cfg) begin
         cfg_we = 1'b1; cfg_src = s[1:0]; cfg_div = d[DIV_W-1:0];
      end
      @(posedge osc_clk);
      #1;
      auto_we = 1'b0; cfg_we = 1'b0;
      if (with_cfg) begin
         exp_src = s; exp_div = d; exp_err = (s >= 2) ? 1 : 0;
      end else begin
         need = (pr == 0) ? 0 : pr - 1;
         if (need <= 63) begin
            exp_src = 0; exp_div = need;
         end else begin
            need = (orr == 0) ? 0 : orr - 1;
            exp_src = 1; exp_div = (need > 63) ? 63 : need;
         end
         exp_err = 0;
      end
   endtask

   task automatic measure(input bit on_pll, input int n, input int runs, input string tag);
      int start, sz, tries, v;
      repeat (20) @(posedge osc_clk);
      start = on_pll ? q_pll.size() : q_osc.size();
      tries = 0;
      sz = start;
      while (sz < start + runs + 1 && tries < 6000) begin
         @(posedge osc_clk);
         tries++;
         sz = on_pll ? q_pll.size() : q_osc.size();
      end
      if (sz < start + runs + 1) begin
         check(1'b0, tag, "runs seen", sz - start, runs + 1);
      end else begin
         for (int k = start + 1; k <= start + runs; k++) begin
            v = on_pll ? q_pll[k] : q_osc[k];
            check(v == n, tag, "half-period length", v, n);
         end
      end
   endtask

   task automatic hold_low(input string tag);
      int bad;
      bad = 0;
      repeat (5) @(posedge osc_clk);
      repeat (40) begin
         @(negedge osc_clk);
         if (clk_out !== 1'b0) bad++;
      end
      check(bad == 0, tag, "high samples while source invalid", bad, 0);
   endtask

   initial begin
      #1_500_000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual 1 expected 0");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int idx, tries;
      // R1: reset state
      repeat (5) @(negedge osc_clk);
      check(clk_out == 1'b0, "R1", "clk_out in reset", int'(clk_out), 0);
      rst_n = 1'b1;
      #1;
      check(rd_src == 2'd1, "R1", "rd_src after reset", int'(rd_src), 1);
      check(rd_div == '0, "R1", "rd_div after reset", int'(rd_div), 0);
      check(src_err == 1'b0, "R1", "src_err after reset", int'(src_err), 0);
      model_on = 1'b1;
      measure(1'b0, 1, 4, "R3");

      // R3 / R4: direct writes, both sources, odd and even lengths
      cfg_write(1, 4);   measure(1'b0, 5, 4, "R3");
      cfg_write(0, 2);   measure(1'b1, 3, 4, "R4");
      cfg_write(0, 5);   measure(1'b1, 6, 4, "R4");
      cfg_write(0, 63);  measure(1'b1, 64, 4, "R3");
      // R10: back to the oscillator
      cfg_write(1, 3);   measure(1'b0, 4, 4, "R10");

      // R6: assisted write that fits
      auto_write(10, 0, 1'b0, 0, 0);  measure(1'b1, 10, 4, "R6");
      auto_write(64, 5, 1'b0, 0, 0);
      #2 check(rd_div == 6'd63 && rd_src == 2'd0, "R6", "ratio 64 divider", int'(rd_div), 63);
      auto_write(0, 5, 1'b0, 0, 0);
      #2 check(rd_div == 6'd0 && rd_src == 2'd0, "R6", "ratio 0 divider", int'(rd_div), 0);

      // R7: fallback to the oscillator
      auto_write(65, 8, 1'b0, 0, 0);
      #2 check(rd_src == 2'd1, "R7", "fallback source", int'(rd_src), 1);
      measure(1'b0, 8, 4, "R7");
      auto_write(500, 200, 1'b0, 0, 0);
      #2 check(rd_div == 6'd63 && rd_src == 2'd1, "R7", "saturated divider", int'(rd_div), 63);

      // R8: both strobes together
      auto_write(10, 0, 1'b1, 1, 2);
      #2 check(rd_src == 2'd1 && rd_div == 6'd2, "R8", "direct write priority",
               int'(rd_div), 2);

      // R5: unsupported codes
      cfg_write(2, 5);   hold_low("R5");
      check(src_err == 1'b1, "R5", "src_err code 2", int'(src_err), 1);
      cfg_write(3, 1);   hold_low("R5");
      check(src_err == 1'b1, "R5", "src_err code 3", int'(src_err), 1);
      cfg_write(1, 1);
      #2 check(src_err == 1'b0, "R5", "src_err cleared", int'(src_err), 0);
      measure(1'b0, 2, 4, "R5");

      // R9: divider change in the middle of a half-period
      cfg_write(1, 9);
      repeat (30) @(posedge osc_clk);
      tries = 0;
      @(posedge osc_clk); #3;
      while (clk_out !== 1'b0 && tries < 100) begin @(posedge osc_clk); #3; tries++; end
      while (clk_out !== 1'b1 && tries < 200) begin @(posedge osc_clk); #3; tries++; end
      @(negedge osc_clk); #1;
      idx = q_osc.size();
      repeat (2) @(posedge osc_clk);
      cfg_write(1, 2);
      repeat (40) @(posedge osc_clk);
      if (q_osc.size() < idx + 3) begin
         check(1'b0, "R9", "runs seen", q_osc.size() - idx, 3);
      end else begin
         check(q_osc[idx] == 10, "R9", "half-period spanning the write", q_osc[idx], 10);
         check(q_osc[idx+1] == 3, "R9", "first new half-period", q_osc[idx+1], 3);
         check(q_osc[idx+2] == 3, "R9", "second new half-period", q_osc[idx+2], 3);
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule